// File: doc/BRIEF.md
# Conditional Return Stack Unit

This unit sits beside a processor's fetch logic and keeps a small hardware stack of return addresses. A call request pushes the address that follows the calling instruction and redirects the instruction pointer to the call target. A return request carries a condition-select code. The unit evaluates that code against the carry flag, the sign flag and a zero flag that it derives from the accumulator. Only when the condition holds does it pop the newest return address and redirect the instruction pointer to it.

When the condition fails, the return does nothing at all. The stack pointer, the depth, the stored entries and the instruction pointer output all stay as they were. Redirects appear one clock after the request, as a registered address together with a one-cycle load strobe. The stack pointer wraps, so a push onto a full stack replaces the oldest entry. A pop from an empty stack sets a sticky underflow flag and still returns whatever entry sits at the wrapped read position.

Top module: `cond_ret_stack`

## Requirements
- R1: After reset, ip_load is 0, ip_next is 0, depth is 0, stk_empty is 1, stk_full is 0, underflow is 0, and every stack entry reads as 0.
- R2: When call_req is 1, one cycle later ip_load is 1 and ip_next equals call_target. The value cur_ip+1 (modulo 2^16) is pushed, and depth rises by one but stops at 8.
- R3: cond_sel encodes the return condition: 3'b000 always, 3'b001 carry=1, 3'b010 carry=0, 3'b011 zero=1, 3'b100 zero=0, 3'b101 sign=1. Codes 3'b110 and 3'b111 are never true.
- R4: The zero flag is 1 exactly when acc equals 8'h00.
- R5: For a return whose condition is true, one cycle later ip_load is 1 and ip_next is the most recently pushed address that has not yet been popped (last in, first out). If depth was non-zero, it falls by one.
- R6: For a return whose condition is false, one cycle later ip_load is 0, and ip_next and depth hold their values. No stack entry or pointer changes, so later pops return the same addresses.
- R7: When call_req and ret_req are both 1, the call is performed and the return is ignored.
- R8: The stack holds 8 entries and its pointer wraps. A ninth push overwrites the oldest entry, depth stays 8, and stk_full is 1 while depth is 8.
- R9: A true return while depth is 0 sets underflow, which then stays 1 until reset. ip_load is 1, ip_next is the entry at the wrapped read position, and depth stays 0.
- R10: With neither request active, one cycle later ip_load is 0 and ip_next and depth hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| call_req | input | 1 | Push return address and jump to call_target |
| ret_req | input | 1 | Conditional return request |
| cond_sel | input | 3 | Return condition code |
| flag_c | input | 1 | Carry flag |
| flag_s | input | 1 | Sign flag |
| acc | input | 8 | Accumulator, zero-tested for the zero flag |
| cur_ip | input | 16 | Address of the current instruction |
| call_target | input | 16 | Destination of a call |
| ip_next | output | 16 | Registered redirect address |
| ip_load | output | 1 | One-cycle strobe: ip_next is a new instruction pointer |
| depth | output | 4 | Number of valid entries, 0 to 8 |
| stk_empty | output | 1 | depth is 0 |
| stk_full | output | 1 | depth is 8 |
| underflow | output | 1 | Sticky: a pop happened on an empty stack |

## Verification
On every cycle, the assertions check the following:
- a false-condition return and an idle cycle leave the strobe low and keep ip_next and depth steady;
- a true return lowers a non-zero depth by one and raises the strobe;
- a call always redirects to its target;
- a simultaneous call wins;
- underflow never clears.

Only the bench's scenarios can show the stored data itself. These scenarios cover last-in-first-out order across a pointer wrap, the survival of entries through refused returns, the value returned by an underflowing pop, and the full truth table of the condition codes against the flags and the accumulator.

// File: rtl/crs_pkg.sv
package crs_pkg;

  typedef enum logic [2:0] {
    COND_ALWAYS = 3'd0,
    COND_CY     = 3'd1,
    COND_NCY    = 3'd2,
    COND_ZR     = 3'd3,
    COND_NZR    = 3'd4,
    COND_NEG    = 3'd5
  } cond_e;

  typedef struct packed {
    logic cy;
    logic zr;
    logic neg;
  } flags_t;

  function automatic logic cond_holds(input logic [2:0] sel, input flags_t f);
    logic r;
    case (sel)
      COND_ALWAYS: r = 1'b1;
      COND_CY:     r = f.cy;
      COND_NCY:    r = ~f.cy;
      COND_ZR:     r = f.zr;
      COND_NZR:    r = ~f.zr;
      COND_NEG:    r = f.neg;
      default:     r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/crs_rst_sync.sv
module crs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/crs_cond_eval.sv
module crs_cond_eval
  import crs_pkg::*;
#(
  parameter int ACC_W = 8
) (
  input  logic [2:0]       cond_sel,
  input  logic             flag_c,
  input  logic             flag_s,
  input  logic [ACC_W-1:0] acc,
  output logic             cond_true
);
  flags_t flags;

  always_comb begin
    flags.cy  = flag_c;
    flags.zr  = (acc == '0);
    flags.neg = flag_s;
    cond_true = cond_holds(cond_sel, flags);
  end
endmodule

// File: rtl/crs_stack_mem.sv
module crs_stack_mem #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [ADDR_W-1:0] rd_data
);
  logic [ADDR_W-1:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic              ent_en;
    logic [ADDR_W-1:0] ent_d;

    always_comb begin
      ent_en = wr_en && (wr_ptr == PTR_W'(g));
      ent_d  = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q[g] <= '0;
      else if (ent_en) ent_q[g] <= ent_d;
    end
  end

  assign rd_data = ent_q[rd_ptr];
endmodule

// File: rtl/crs_ptr_ctrl.sv
module crs_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] depth,
  output logic             uflow
);
  logic [PTR_W-1:0] sp_q, sp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             uf_q, uf_d;
  logic             st_en;

  always_comb begin
    sp_d  = sp_q;
    cnt_d = cnt_q;
    uf_d  = uf_q;
    st_en = push | pop;
    if (push) begin
      sp_d = sp_q + PTR_W'(1);
      if (cnt_q != CNT_W'(DEPTH)) cnt_d = cnt_q + CNT_W'(1);
    end else if (pop) begin
      sp_d = sp_q - PTR_W'(1);
      if (cnt_q == '0) uf_d  = 1'b1;
      else             cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      cnt_q <= '0;
      uf_q  <= 1'b0;
    end else if (st_en) begin
      sp_q  <= sp_d;
      cnt_q <= cnt_d;
      uf_q  <= uf_d;
    end
  end

  assign wr_ptr = sp_q;
  assign rd_ptr = sp_q - PTR_W'(1);
  assign depth  = cnt_q;
  assign uflow  = uf_q;
endmodule

// File: rtl/cond_ret_stack.sv
module cond_ret_stack #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int ACC_W  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_req,
  input  logic              ret_req,
  input  logic [2:0]        cond_sel,
  input  logic              flag_c,
  input  logic              flag_s,
  input  logic [ACC_W-1:0]  acc,
  input  logic [ADDR_W-1:0] cur_ip,
  input  logic [ADDR_W-1:0] call_target,
  output logic [ADDR_W-1:0] ip_next,
  output logic              ip_load,
  output logic [CNT_W-1:0]  depth,
  output logic              stk_empty,
  output logic              stk_full,
  output logic              underflow
);
  logic              rst_sync_n;
  logic              cond_true;
  logic              push, pop;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [ADDR_W-1:0] ret_addr;
  logic [ADDR_W-1:0] link_addr;
  logic [ADDR_W-1:0] ip_d, ip_q;
  logic              ip_en;
  logic              load_q;

  crs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  crs_cond_eval #(.ACC_W(ACC_W)) u_cond (
    .cond_sel  (cond_sel),
    .flag_c    (flag_c),
    .flag_s    (flag_s),
    .acc       (acc),
    .cond_true (cond_true)
  );

  always_comb begin
    push      = call_req;
    pop       = ret_req & ~call_req & cond_true;
    link_addr = cur_ip + ADDR_W'(1);
  end

  crs_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .push   (push),
    .pop    (pop),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .depth  (depth),
    .uflow  (underflow)
  );

  crs_stack_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (push),
    .wr_ptr  (wr_ptr),
    .wr_data (link_addr),
    .rd_ptr  (rd_ptr),
    .rd_data (ret_addr)
  );

  always_comb begin
    ip_en = push | pop;
    ip_d  = push ? call_target : ret_addr;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ip_q <= '0;
    else if (ip_en)   ip_q <= ip_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) load_q <= 1'b0;
    else             load_q <= ip_en;
  end

  assign ip_next   = ip_q;
  assign ip_load   = load_q;
  assign stk_empty = (depth == '0);
  assign stk_full  = (depth == CNT_W'(DEPTH));
endmodule

// File: rtl/crs_checker.sv
module crs_checker #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int ACC_W  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              call_req,
  input logic              ret_req,
  input logic [2:0]        cond_sel,
  input logic [ACC_W-1:0]  acc,
  input logic              cond_true,
  input logic [ADDR_W-1:0] call_target,
  input logic [ADDR_W-1:0] ip_next,
  input logic              ip_load,
  input logic [CNT_W-1:0]  depth,
  input logic              underflow
);
  // R2
  p_call_target_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    call_req |=> ip_load && ip_next == $past(call_target));

  // R4
  p_zero_acc_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ret_req && !call_req && cond_sel == 3'b011 && acc == '0) |=> ip_load);

  // R5
  p_pop_true_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ret_req && !call_req && cond_true && depth != '0)
      |=> ip_load && depth == $past(depth) - CNT_W'(1));

  // R6
  p_hold_false_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ret_req && !call_req && !cond_true)
      |=> !ip_load && $stable(ip_next) && $stable(depth));

  // R7
  p_call_wins_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (call_req && ret_req && depth != CNT_W'(DEPTH))
      |=> depth == $past(depth) + CNT_W'(1));

  // R8
  p_depth_bound_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    depth <= CNT_W'(DEPTH));

  // R9
  p_uflow_sticky_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    underflow |=> underflow);

  // R10
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!call_req && !ret_req) |=> !ip_load && $stable(ip_next) && $stable(depth));
endmodule

bind cond_ret_stack crs_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .ACC_W(ACC_W)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .call_req    (call_req),
  .ret_req     (ret_req),
  .cond_sel    (cond_sel),
  .acc         (acc),
  .cond_true   (cond_true),
  .call_target (call_target),
  .ip_next     (ip_next),
  .ip_load     (ip_load),
  .depth       (depth),
  .underflow   (underflow)
);

// File: tb/cond_ret_stack_test.sv
`timescale 1ns/1ps
module cond_ret_stack_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        call_req, ret_req, flag_c, flag_s;
  logic [2:0]  cond_sel;
  logic [7:0]  acc;
  logic [15:0] cur_ip, call_target;
  logic [15:0] ip_next;
  logic        ip_load, stk_empty, stk_full, underflow;
  logic [3:0]  depth;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  logic [15:0] m_mem [8];
  int          m_sp, m_depth;
  bit          m_uf;
  logic [15:0] m_ip;
  bit          m_load;

  always #2.5 clk = ~clk;

  cond_ret_stack uut (
    .clk(clk), .rst_n(rst_n), .call_req(call_req), .ret_req(ret_req),
    .cond_sel(cond_sel), .flag_c(flag_c), .flag_s(flag_s), .acc(acc),
    .cur_ip(cur_ip), .call_target(call_target), .ip_next(ip_next),
    .ip_load(ip_load), .depth(depth), .stk_empty(stk_empty),
    .stk_full(stk_full), .underflow(underflow)
  );

  function automatic bit cond_ok(input logic [2:0] sel, input bit c,
                                 input logic [7:0] a, input bit s);
    bit z = (a == 8'h00);
    case (sel)
      3'd0: return 1'b1;
      3'd1: return c;
      3'd2: return !c;
      3'd3: return z;
      3'd4: return !z;
      3'd5: return s;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, "ip_load", {31'd0, ip_load}, {31'd0, m_load});
    check(tag, "ip_next", {16'd0, ip_next}, {16'd0, m_ip});
    check(tag, "depth", {28'd0, depth}, m_depth);
    check(tag, "underflow", {31'd0, underflow}, {31'd0, m_uf});
    check(tag, "stk_empty", {31'd0, stk_empty}, {31'd0, m_depth == 0});
    check(tag, "stk_full", {31'd0, stk_full}, {31'd0, m_depth == 8});
  endtask

  task automatic step(input bit call, input bit ret, input logic [2:0] sel,
                      input bit c, input logic [7:0] a, input bit s,
                      input logic [15:0] tgt, input logic [15:0] ip,
                      input string tag);
    call_req = call; ret_req = ret; cond_sel = sel; flag_c = c;
    acc = a; flag_s = s; call_target = tgt; cur_ip = ip;
    if (call) begin
      m_mem[m_sp] = ip + 16'd1;
      m_sp = (m_sp + 1) % 8;
      if (m_depth < 8) m_depth++;
      m_ip = tgt; m_load = 1;
    end else if (ret && cond_ok(sel, c, a, s)) begin
      m_sp = (m_sp + 7) % 8;
      m_ip = m_mem[m_sp];
      if (m_depth == 0) m_uf = 1; else m_depth--;
      m_load = 1;
    end else begin
      m_load = 0;
    end
    @(posedge clk);
    @(negedge clk);
    call_req = 0; ret_req = 0;
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    call_req = 0; ret_req = 0; cond_sel = 0; flag_c = 0; flag_s = 0;
    acc = 8'h11; cur_ip = 0; call_target = 0;
    for (int i = 0; i < 8; i++) m_mem[i] = 16'h0;
    m_sp = 0; m_depth = 0; m_uf = 0; m_ip = 0; m_load = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    check_all("R1");

    // R10 idle
    step(0, 0, 3'd0, 0, 8'h11, 0, 16'h0, 16'h0, "R10");

    // R2 calls
    step(1, 0, 3'd0, 0, 8'h11, 0, 16'h2000, 16'h0100, "R2");
    step(1, 0, 3'd0, 0, 8'h11, 0, 16'h3000, 16'hFFFF, "R2");

    // R3 / R6: carry conditions false then true
    step(0, 1, 3'd1, 0, 8'h11, 0, 16'h0, 16'h0, "R6");
    step(0, 1, 3'd2, 1, 8'h11, 0, 16'h0, 16'h0, "R6");
    step(0, 1, 3'd5, 0, 8'h11, 0, 16'h0, 16'h0, "R3");
    step(0, 1, 3'd6, 1, 8'h00, 1, 16'h0, 16'h0, "R3");
    step(0, 1, 3'd7, 1, 8'h00, 1, 16'h0, 16'h0, "R3");
    step(0, 1, 3'd1, 1, 8'h11, 0, 16'h0, 16'h0, "R5");

    // R4: zero flag from accumulator
    step(1, 0, 3'd0, 0, 8'h11, 0, 16'h4000, 16'h0200, "R2");
    step(0, 1, 3'd3, 0, 8'h01, 0, 16'h0, 16'h0, "R4");
    step(0, 1, 3'd4, 0, 8'h00, 0, 16'h0, 16'h0, "R4");
    step(0, 1, 3'd3, 0, 8'h00, 0, 16'h0, 16'h0, "R4");
    step(0, 1, 3'd4, 0, 8'h80, 0, 16'h0, 16'h0, "R4");

    // R7 call + ret together
    step(1, 1, 3'd0, 0, 8'h11, 0, 16'h5000, 16'h0300, "R7");

    // R8 fill past capacity, then drain in LIFO order
    for (int i = 0; i < 10; i++)
      step(1, 0, 3'd0, 0, 8'h11, 0, 16'h6000 + 16'(i), 16'h0A00 + 16'(i), "R8");
    for (int i = 0; i < 8; i++)
      step(0, 1, 3'd0, 0, 8'h11, 0, 16'h0, 16'h0, "R8");

    // R9 underflow
    step(0, 1, 3'd0, 0, 8'h11, 0, 16'h0, 16'h0, "R9");
    step(0, 0, 3'd0, 0, 8'h11, 0, 16'h0, 16'h0, "R9");
    step(0, 1, 3'd5, 1, 8'h11, 1, 16'h0, 16'h0, "R9");

    // Random mix covering R2 R3 R5 R6 R7 R10
    for (int i = 0; i < 1500; i++) begin
      int unsigned r = $urandom;
      step(r[0] & r[1] & r[2], r[3] | r[4], 3'(r[7:5]), r[8], (r[9] ? 8'h00 : 8'(r[17:10])),
           r[18], 16'($urandom), 16'($urandom), "R5_R6_rnd");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule